// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a keypad wired as a matrix of 5 drive columns and 6 sense rows, with both sides active low. A divider turns the system clock into a 1 ms scan tick. All scanning and debounce timing moves forward only on that tick, and only while the keypad clock enable is high. At rest, every column is driven low and the block waits for any row to fall. When a row falls, the block waits one debounce period. If a row is still low after that period, it visits the columns one at a time in a programmable order. In each column it samples the six rows in fixed order, holding each row for a programmable interval.

A key counts only when exactly one column and row intersection read as pressed during the whole scan. For a valid key, the block loads a column register and a row register and pulses an interrupt. If more than one intersection reads as pressed, nothing is reported. After any scan, the block waits until all rows are high and then debounces the release before it goes back to rest.

When scan enable is low, the column pins follow the column register, and software may write that register to scan the keypad by hand while it reads the rows directly.

Top module: `kps_top`

## Requirements
- R1: The scan tick is one clock cycle long and occurs every CLK_HZ/TICK_HZ cycles while `kb_en` is high. With `kb_en` low there is no tick, the scanner state does not advance, and no key is reported even while a key is held.
- R2: With `scan_en` high and no scan in progress, `col_n` is 5'b00000. A row reading low on a tick starts the press debounce.
- R3: Both debounce periods last (dbnc_cfg[5:0]+1)×4 ticks, and bits 7:6 of `dbnc_cfg` have no effect. If every row is high when the press debounce ends, the block returns to rest without scanning.
- R4: A scan visits entries 0 to 4 of `col_order`, where entry i is bits [3i+2:3i]. While entry i is active, `col_n` has only bit `entry` low, or is 5'b11111 if the entry is 5 or more. Each entry lasts 6×(scan_cfg+1) ticks, with rows sampled in order 0 to 5, one every scan_cfg+1 ticks. The order is captured when the scan starts.
- R5: A scan with exactly one low sample sets `key_col_n` to all ones except bit c, and sets `key_row_n` to all ones except bit r. In the same cycle, `key_irq` is high for exactly one cycle.
- R6: A scan with two or more low samples, or with none, leaves `key_col_n` and `key_row_n` unchanged and gives no `key_irq`.
- R7: After a scan ends, the columns stay at 5'b00000 until all rows have been high on a tick. The release debounce then starts. A low row on any tick during the release debounce restarts it. When it expires, the block returns to rest.
- R8: With `scan_en` low, `col_n` equals `key_col_n`, and a write with `sw_col_we` loads `sw_col` into `key_col_n` on the next cycle. With `scan_en` high, writes are ignored. Clearing `scan_en` aborts any scan with no report.
- R9: After reset, `key_col_n` is 5'b11111, `key_row_n` is 6'b111111 and `key_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_en | input | 1 | Keypad clock enable; gates the scan tick |
| scan_en | input | 1 | Hardware scanning on (1) or bypass (0) |
| dbnc_cfg | input | 8 | Debounce length field; bits 5:0 used |
| scan_cfg | input | 2 | Per-row sample interval minus one, in ticks |
| col_order | input | 15 | Five 3-bit column indices in visiting order, entry 0 in the LSBs |
| sw_col_we | input | 1 | Software write strobe for the column register |
| sw_col | input | 5 | Software column value |
| row_n | input | 6 | Sense rows, active low, synchronous to clk |
| col_n | output | 5 | Drive columns, active low |
| key_col_n | output | 5 | Column register, one-cold for a detected key |
| key_row_n | output | 6 | Row register, one-cold for a detected key |
| key_irq | output | 1 | One-cycle pulse on a valid key |

## Verification
Two events can land on the same clock edge: the last row sample of a scan, which would load the key registers and raise the interrupt, and software clearing scan enable while also writing the column register. The bench waits until its model shows that the next edge carries both the tick and the final sample. It then clears scan enable and writes the column register in that cycle. The expected result is that no interrupt occurs, the column register takes the software value and the row register stays as it was. A cycle-level model also checks every output on every clock through bouncing presses, bouncing releases, double presses and columns left out of the order.

// File: rtl/kps_pkg.sv
package kps_pkg;
    localparam int unsigned NCOL = 5;
    localparam int unsigned NROW = 6;
    localparam int unsigned CIW  = 3;
    localparam int unsigned RIW  = 3;
    localparam int unsigned ORDW = NCOL * CIW;
    localparam int unsigned TMRW = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESS_DB,
        ST_SCAN,
        ST_WAIT_REL,
        ST_REL_DB
    } scan_state_e;

    typedef struct packed {
        logic [CIW-1:0] col;
        logic [RIW-1:0] row;
    } key_pos_t;

    // Debounce length in ticks: (low six bits + 1) * 4
    function automatic logic [TMRW-1:0] dbnc_ticks(input logic [7:0] cfg);
        logic [7:0] used;
        used = cfg & 8'h3F;
        return ({1'b0, used} + 9'd1) << 2;
    endfunction

    // Per-row sample interval in ticks
    function automatic logic [TMRW-1:0] step_ticks(input logic [1:0] cfg);
        return {7'd0, cfg} + 9'd1;
    endfunction

    function automatic logic [NCOL-1:0] col_onecold(input logic [CIW-1:0] idx);
        logic [NCOL-1:0] r;
        r = '1;
        for (int i = 0; i < int'(NCOL); i++) begin
            if (idx == CIW'(i)) r[i] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [NROW-1:0] row_onecold(input logic [RIW-1:0] idx);
        logic [NROW-1:0] r;
        r = '1;
        for (int i = 0; i < int'(NROW); i++) begin
            if (idx == RIW'(i)) r[i] = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/kps_tick.sv
module kps_tick #(
    parameter int unsigned DIV = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/kps_fsm.sv
module kps_fsm
    import kps_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_en,
    input  logic            tick,
    input  logic [NROW-1:0] row_n,
    input  logic [7:0]      dbnc_cfg,
    input  logic [1:0]      scan_cfg,
    input  logic [ORDW-1:0] col_order,
    output logic [NCOL-1:0] drive_n,
    output logic            load,
    output key_pos_t        load_pos
);
    scan_state_e     st;
    logic [TMRW-1:0] tmr;
    logic [CIW-1:0]  col_pos;
    logic [RIW-1:0]  row_pos;
    logic [1:0]      hits;
    key_pos_t        hit;
    logic [ORDW-1:0] order_q;

    logic            any_low;
    logic [TMRW-1:0] dlen;
    logic [TMRW-1:0] slen;
    logic [CIW-1:0]  entry;
    logic            hit_now;
    logic [1:0]      hits_inc;
    logic            step_end;
    logic            last_row;
    logic            last_col;
    logic            scan_done;

    always_comb begin
        any_low   = ~&row_n;
        dlen      = dbnc_ticks(dbnc_cfg);
        slen      = step_ticks(scan_cfg);
        entry     = order_q[col_pos*CIW +: CIW];
        hit_now   = ~row_n[row_pos];
        hits_inc  = (hits == 2'd2) ? 2'd2 : hits + 2'd1;
        step_end  = (tmr == slen - 9'd1);
        last_row  = (row_pos == RIW'(NROW - 1));
        last_col  = (col_pos == CIW'(NCOL - 1));
        scan_done = scan_en && tick && (st == ST_SCAN) && step_end && last_row && last_col;
        load      = scan_done && (hit_now ? (hits == 2'd0) : (hits == 2'd1));
        load_pos  = hit_now ? '{col: entry, row: row_pos} : hit;
        drive_n   = (st == ST_SCAN) ? col_onecold(entry) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            tmr     <= '0;
            col_pos <= '0;
            row_pos <= '0;
            hits    <= '0;
            hit     <= '0;
            order_q <= '0;
        end else if (!scan_en) begin
            st  <= ST_IDLE;
            tmr <= '0;
        end else if (tick) begin
            unique case (st)
                ST_IDLE: begin
                    if (any_low) begin
                        st  <= ST_PRESS_DB;
                        tmr <= '0;
                    end
                end
                ST_PRESS_DB: begin
                    if (tmr == dlen - 9'd1) begin
                        tmr <= '0;
                        if (any_low) begin
                            st      <= ST_SCAN;
                            order_q <= col_order;
                            col_pos <= '0;
                            row_pos <= '0;
                            hits    <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        tmr <= tmr + 9'd1;
                    end
                end
                ST_SCAN: begin
                    if (step_end) begin
                        tmr <= '0;
                        if (hit_now) begin
                            hits <= hits_inc;
                            hit  <= '{col: entry, row: row_pos};
                        end
                        if (last_row) begin
                            row_pos <= '0;
                            if (last_col) begin
                                col_pos <= '0;
                                st      <= ST_WAIT_REL;
                            end else begin
                                col_pos <= col_pos + 3'd1;
                            end
                        end else begin
                            row_pos <= row_pos + 3'd1;
                        end
                    end else begin
                        tmr <= tmr + 9'd1;
                    end
                end
                ST_WAIT_REL: begin
                    if (!any_low) begin
                        st  <= ST_REL_DB;
                        tmr <= '0;
                    end
                end
                ST_REL_DB: begin
                    if (any_low) begin
                        tmr <= '0;
                    end else if (tmr == dlen - 9'd1) begin
                        st <= ST_IDLE;
                    end else begin
                        tmr <= tmr + 9'd1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/kps_regs.sv
module kps_regs
    import kps_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_en,
    input  logic            load,
    input  key_pos_t        load_pos,
    input  logic            sw_we,
    input  logic [NCOL-1:0] sw_col,
    input  logic [NCOL-1:0] drive_n,
    output logic [NCOL-1:0] col_n,
    output logic [NCOL-1:0] kcol_n,
    output logic [NROW-1:0] krow_n,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            kcol_n <= '1;
            krow_n <= '1;
            irq    <= 1'b0;
        end else begin
            irq <= load;
            if (load) begin
                kcol_n <= col_onecold(load_pos.col);
                krow_n <= row_onecold(load_pos.row);
            end else if (sw_we && !scan_en) begin
                kcol_n <= sw_col;
            end
        end
    end

    assign col_n = scan_en ? drive_n : kcol_n;
endmodule

// File: rtl/kps_top.sv
module kps_top
    import kps_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 12_000_000,
    parameter int unsigned TICK_HZ = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        kb_en,
    input  logic        scan_en,
    input  logic [7:0]  dbnc_cfg,
    input  logic [1:0]  scan_cfg,
    input  logic [14:0] col_order,
    input  logic        sw_col_we,
    input  logic [4:0]  sw_col,
    input  logic [5:0]  row_n,
    output logic [4:0]  col_n,
    output logic [4:0]  key_col_n,
    output logic [5:0]  key_row_n,
    output logic        key_irq
);
    localparam int unsigned DIV = CLK_HZ / TICK_HZ;

    logic            tick;
    logic [NCOL-1:0] drive_n;
    logic            load;
    key_pos_t        load_pos;

    kps_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (kb_en),
        .tick (tick)
    );

    kps_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (scan_en),
        .tick      (tick),
        .row_n     (row_n),
        .dbnc_cfg  (dbnc_cfg),
        .scan_cfg  (scan_cfg),
        .col_order (col_order),
        .drive_n   (drive_n),
        .load      (load),
        .load_pos  (load_pos)
    );

    kps_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .load     (load),
        .load_pos (load_pos),
        .sw_we    (sw_col_we),
        .sw_col   (sw_col),
        .drive_n  (drive_n),
        .col_n    (col_n),
        .kcol_n   (key_col_n),
        .krow_n   (key_row_n),
        .irq      (key_irq)
    );
endmodule

// File: rtl/kps_chk.sv
module kps_chk (
    input logic       clk,
    input logic       rst,
    input logic       kb_en,
    input logic       scan_en,
    input logic       tick,
    input logic [4:0] col_n,
    input logic [4:0] key_col_n,
    input logic [5:0] key_row_n,
    input logic       key_irq
);
    // R1
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !kb_en |=> !tick);

    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        key_irq |=> !key_irq);

    // R6
    row_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (key_row_n != $past(key_row_n)) |-> key_irq);

    // R4
    one_col_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> (col_n == 5'b00000 || $countones(~col_n) <= 1));

    // R7
    rel_low_chk: assert property (@(posedge clk) disable iff (rst)
        (key_irq && scan_en) |-> (col_n == 5'b00000));

    // R8
    bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (key_col_n != $past(key_col_n)) |-> (key_irq || !$past(scan_en)));
endmodule

bind kps_top kps_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .kb_en     (kb_en),
    .scan_en   (scan_en),
    .tick      (tick),
    .col_n     (col_n),
    .key_col_n (key_col_n),
    .key_row_n (key_row_n),
    .key_irq   (key_irq)
);

// File: tb/kps_top_tb_top.sv
module kps_top_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kb_en = 1'b0;
    logic        scan_en = 1'b0;
    logic [7:0]  dbnc_cfg = 8'hC1;
    logic [1:0]  scan_cfg = 2'd1;
    logic [14:0] col_order = 15'd0;
    logic        sw_col_we = 1'b0;
    logic [4:0]  sw_col = 5'd0;
    logic [5:0]  row_n;
    logic [4:0]  col_n;
    logic [4:0]  key_col_n;
    logic [5:0]  key_row_n;
    logic        key_irq;

    logic [29:0] keys = 30'd0;

    int n_chk = 0;
    int n_bad = 0;
    int n_irq = 0;
    int cyc = 0;

    kps_top #(.CLK_HZ(4000), .TICK_HZ(1000)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .kb_en     (kb_en),
        .scan_en   (scan_en),
        .dbnc_cfg  (dbnc_cfg),
        .scan_cfg  (scan_cfg),
        .col_order (col_order),
        .sw_col_we (sw_col_we),
        .sw_col    (sw_col),
        .row_n     (row_n),
        .col_n     (col_n),
        .key_col_n (key_col_n),
        .key_row_n (key_row_n),
        .key_irq   (key_irq)
    );

    always #5 clk = ~clk;

    // keypad matrix emulation
    always_comb begin
        row_n = 6'h3F;
        for (int c = 0; c < 5; c++)
            for (int r = 0; r < 6; r++)
                if (keys[c*6+r] && !col_n[c]) row_n[r] = 1'b0;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_cnt, m_st, m_left, m_ci, m_ri, m_hits, m_hc, m_hr;
    logic        m_tick, m_irq;
    logic [14:0] m_ord;
    logic [4:0]  m_kcol;
    logic [5:0]  m_krow;

    function automatic int ent(input logic [14:0] o, input int i);
        return int'(o[3*i +: 3]);
    endfunction

    function automatic logic [4:0] drive_of(input int e);
        if (e < 5) return ~(5'b00001 << e);
        return 5'h1F;
    endfunction

    always @(posedge clk) begin
        logic tnow;
        int   dl;
        dl = (int'(dbnc_cfg[5:0]) + 1) * 4;
        if (rst) begin
            m_cnt = 0; m_tick = 0; m_st = 0; m_left = 0; m_ci = 0; m_ri = 0;
            m_hits = 0; m_hc = 0; m_hr = 0; m_ord = 0;
            m_kcol = 5'h1F; m_krow = 6'h3F; m_irq = 0;
        end else begin
            tnow = m_tick;
            if (!kb_en) begin
                m_cnt = 0; m_tick = 0;
            end else if (m_cnt == DIV - 1) begin
                m_cnt = 0; m_tick = 1;
            end else begin
                m_cnt++; m_tick = 0;
            end
            m_irq = 0;
            if (!scan_en) begin
                if (sw_col_we) m_kcol = sw_col;
                m_st = 0;
            end else if (tnow) begin
                case (m_st)
                    0: if (row_n != 6'h3F) begin m_st = 1; m_left = dl; end
                    1: begin
                        m_left--;
                        if (m_left == 0) begin
                            if (row_n != 6'h3F) begin
                                m_st = 2; m_ord = col_order; m_ci = 0; m_ri = 0;
                                m_hits = 0; m_left = int'(scan_cfg) + 1;
                            end else m_st = 0;
                        end
                    end
                    2: begin
                        m_left--;
                        if (m_left == 0) begin
                            if (!row_n[m_ri]) begin
                                m_hits++; m_hc = ent(m_ord, m_ci); m_hr = m_ri;
                            end
                            m_left = int'(scan_cfg) + 1;
                            m_ri++;
                            if (m_ri == 6) begin
                                m_ri = 0; m_ci++;
                                if (m_ci == 5) begin
                                    m_ci = 0; m_st = 3;
                                    if (m_hits == 1) begin
                                        m_kcol = ~(5'b00001 << m_hc);
                                        m_krow = ~(6'b000001 << m_hr);
                                        m_irq  = 1;
                                    end
                                end
                            end
                        end
                    end
                    3: if (row_n == 6'h3F) begin m_st = 4; m_left = dl; end
                    4: begin
                        if (row_n != 6'h3F) m_left = dl;
                        else begin
                            m_left--;
                            if (m_left == 0) m_st = 0;
                        end
                    end
                    default: m_st = 0;
                endcase
            end
        end
    end

    // per-clock comparison and scan-sequence monitor
    logic [4:0] seq[$];
    logic [4:0] last_seen = 5'd0;

    always @(negedge clk) begin
        logic [4:0] ecol;
        if (!scan_en) ecol = m_kcol;
        else if (m_st == 2) ecol = drive_of(ent(m_ord, m_ci));
        else ecol = 5'd0;
        chk("R4 col_n", int'(col_n), int'(ecol));
        chk("R5 key_col_n", int'(key_col_n), int'(m_kcol));
        chk("R5 key_row_n", int'(key_row_n), int'(m_krow));
        chk("R5 key_irq", int'(key_irq), int'(m_irq));
        if (!rst && key_irq) n_irq++;
        if (scan_en && col_n != 5'd0 && col_n != last_seen) seq.push_back(col_n);
        last_seen = scan_en ? col_n : 5'd0;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic key(input int c, input int r, input logic v);
        keys[c*6+r] = v;
    endtask

    initial begin
        int irq0;
        int guard;
        logic [4:0] exp_seq[5];
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);
        // R9 reset state
        chk("R9 key_col_n", int'(key_col_n), 'h1F);
        chk("R9 key_row_n", int'(key_row_n), 'h3F);
        chk("R9 key_irq", int'(key_irq), 0);

        // R1: no tick, no scanning while kb_en is low
        scan_en = 1'b1;
        col_order = {3'd1, 3'd3, 3'd0, 3'd2, 3'd4};
        wait_cyc(1);
        chk("R2 idle columns low", int'(col_n), 0);
        key(0, 0, 1'b1);
        wait_cyc(300);
        chk("R1 no scan without kb_en", int'(col_n), 0);
        chk("R1 no irq without kb_en", n_irq, 0);
        key(0, 0, 1'b0);
        kb_en = 1'b1;
        wait_cyc(20);

        // R5 / R4: single key with scrambled order
        seq.delete();
        key(3, 2, 1'b1);
        wait_cyc(400);
        chk("R5 irq count", n_irq, 1);
        chk("R5 column code", int'(key_col_n), 'h17);
        chk("R5 row code", int'(key_row_n), 'h3B);
        exp_seq = '{5'b01111, 5'b11011, 5'b11110, 5'b10111, 5'b11101};
        chk("R4 visit count", seq.size(), 5);
        for (int i = 0; i < 5; i++)
            if (i < seq.size()) chk("R4 visit order", int'(seq[i]), int'(exp_seq[i]));
        key(3, 2, 1'b0);
        wait_cyc(200);

        // R6: two keys rejected
        irq0 = n_irq;
        key(1, 0, 1'b1);
        key(4, 5, 1'b1);
        wait_cyc(400);
        chk("R6 no irq on double", n_irq, irq0);
        chk("R6 column kept", int'(key_col_n), 'h17);
        chk("R6 row kept", int'(key_row_n), 'h3B);
        key(1, 0, 1'b0);
        key(4, 5, 1'b0);
        wait_cyc(200);

        // R3: short bounce never starts a scan (cfg bits 7:6 set)
        seq.delete();
        key(2, 1, 1'b1);
        wait_cyc(10);
        key(2, 1, 1'b0);
        wait_cyc(300);
        chk("R3 no scan after bounce", seq.size(), 0);
        chk("R3 no irq after bounce", n_irq, irq0);

        // R7: release bounce restarts debounce, no new scan
        key(0, 5, 1'b1);
        wait_cyc(400);
        chk("R7 key reported", n_irq, irq0 + 1);
        seq.delete();
        key(0, 5, 1'b0);
        wait_cyc(12);
        key(0, 5, 1'b1);
        wait_cyc(12);
        key(0, 5, 1'b0);
        wait_cyc(200);
        chk("R7 no scan during release", seq.size(), 0);
        chk("R7 single report", n_irq, irq0 + 1);
        key(4, 0, 1'b1);
        wait_cyc(400);
        chk("R7 back to rest then new key", int'(key_col_n), 'h0F);
        chk("R7 new row", int'(key_row_n), 'h3E);
        key(4, 0, 1'b0);
        wait_cyc(200);

        // R4: column absent from order is never reported
        irq0 = n_irq;
        col_order = {3'd4, 3'd3, 3'd2, 3'd7, 3'd1};
        key(0, 3, 1'b1);
        wait_cyc(400);
        chk("R4 unvisited column", n_irq, irq0);
        key(0, 3, 1'b0);
        wait_cyc(200);

        // R8: bypass writes and pin control
        scan_en = 1'b0;
        wait_cyc(1);
        chk("R8 pins follow register", int'(col_n), int'(key_col_n));
        sw_col = 5'b01010;
        sw_col_we = 1'b1;
        wait_cyc(1);
        sw_col_we = 1'b0;
        chk("R8 write applied", int'(col_n), 'h0A);
        scan_en = 1'b1;
        sw_col = 5'b00000;
        sw_col_we = 1'b1;
        wait_cyc(1);
        sw_col_we = 1'b0;
        chk("R8 write ignored while scanning", int'(key_col_n), 'h0A);
        wait_cyc(10);

        // R8 / R5 coincidence: scan_en cleared on final sample edge
        irq0 = n_irq;
        col_order = {3'd1, 3'd3, 3'd0, 3'd2, 3'd4};
        key(1, 1, 1'b1);
        guard = 0;
        while (!(m_st == 2 && m_ci == 4 && m_ri == 5 && m_left == 1 && m_tick) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk("R8 reached final sample", int'(guard < 2000), 1);
        scan_en = 1'b0;
        sw_col = 5'b11100;
        sw_col_we = 1'b1;
        wait_cyc(1);
        sw_col_we = 1'b0;
        wait_cyc(2);
        chk("R8 aborted scan no irq", n_irq, irq0);
        chk("R8 software value kept", int'(key_col_n), 'h1C);
        chk("R8 row register kept", int'(key_row_n), 'h3E);
        chk("R8 pins show register", int'(col_n), 'h1C);
        key(1, 1, 1'b0);
        wait_cyc(20);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule